// File: doc/BRIEF.md
# Partial Autocorrelation Matrix Accumulator

This block estimates the leading columns of the sample autocorrelation matrix of a complex antenna-array signal. The samples of one snapshot reach it serially, one array element per clock, because the clock runs N times faster than the snapshot rate. A start pulse marks the first element. The block then takes a fixed run of 2^LOG2_SNAPS snapshots back to back. For every element i and every column j below K it accumulates x_i·conj(x_j). At the end it divides the sums by the snapshot count, rounding to nearest, and raises a one-cycle done pulse. The averaged N×K matrix then stays on the outputs until the next start.

The block computes only K columns, so it needs only K complex multiply-accumulate units, one per column. A K-stage delay line feeds these units, and each unit reads the stage one deeper than its neighbour, so each unit runs one cycle behind the previous one. A small bank holds the conjugates of the first K elements of the current snapshot. Because of the skew, each unit takes its conjugate operand only after it has been captured, and finishes with it before the next snapshot overwrites it. The datapath therefore keeps pace with the serial input and needs no second buffer. Later stages, such as a decomposition of these columns, consume the held result.

Top module: `partial_autocorr_acc`

## Requirements
- R1: After reset, done is low and every output entry reads zero.
- R2: The clock edge that samples start clears every accumulator. In the cycle after that edge, all outputs read zero.
- R3: The element sampled on the start edge is element 0 of snapshot 0. The m-th sample after it is element m mod N of snapshot m div N. Exactly N·2^LOG2_SNAPS consecutive samples are taken, with no gaps.
- R4: Entry (i, j) accumulates x_i·conj(x_j) over all snapshots. The real part adds re_i·re_j + im_i·im_j and the imaginary part adds im_i·re_j − re_i·im_j.
- R5: Each output is the accumulated sum plus 2^(LOG2_SNAPS−1), arithmetically shifted right by LOG2_SNAPS. Exact halves therefore round toward positive infinity, so a sum of +32 gives 1 and a sum of −32 gives 0 when LOG2_SNAPS is 6.
- R6: Entry (row i, column j) occupies bits [(i·K + j)·OUT_W +: OUT_W] of avg_re and avg_im, where OUT_W = 2·SAMP_W + 1, and is read as two's complement.
- R7: Count the edge that samples start as edge 0. Done is then high for exactly one cycle, the cycle following edge 64·N + K − 1 (with the default 64 snapshots). Done does not rise at any other time.
- R8: After a run completes, samples arriving after the window are ignored. The outputs hold their values until the next start.
- R9: A start during a run aborts it. Samples already in flight are discarded, the aborted run raises no done, and the result comes only from the new run.
- R10: Full-scale inputs, including −2048 on both parts of every element, give exact results with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Clears the accumulators and marks element 0 of the first snapshot |
| smp_re | input | SAMP_W | Real part of the current array element, signed |
| smp_im | input | SAMP_W | Imaginary part of the current array element, signed |
| done | output | 1 | One-cycle pulse when the averaged matrix is valid |
| avg_re | output | N_ELEM·K_COLS·OUT_W | Packed real parts of the averaged matrix |
| avg_im | output | N_ELEM·K_COLS·OUT_W | Packed imaginary parts of the averaged matrix |

## Verification
The matrix is compared against a bench model for four kinds of input. Uniform random snapshots exercise general accumulation. A per-row ramp gives every row and column a distinct magnitude, which exposes swapped rows, swapped columns or wrong packing. Full-scale constant snapshots, including the most negative value on both parts, show whether the accumulator and the conjugate register have enough headroom. A sparse snapshot whose sums land exactly on ±half an LSB separates the required tie behaviour from truncation or symmetric rounding. An aborted run followed by a fresh start shows whether in-flight samples leak into the new sums. The done timing and the held result are checked against garbage input driven after each window.

// File: rtl/pac_pkg.sv
package pac_pkg;

   localparam int unsigned DEF_N  = 8;
   localparam int unsigned DEF_K  = 3;
   localparam int unsigned DEF_W  = 12;
   localparam int unsigned DEF_LG = 6;

   // product of a W-bit sample and a conjugated sample fits 2W+1 bits;
   // 2^lg of them need lg more
   function automatic int unsigned acc_width(int unsigned w, int unsigned lg);
      return 2 * w + 1 + lg;
   endfunction

   function automatic int unsigned idx_width(int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/pac_skew_line.sv
module pac_skew_line #(
   parameter int unsigned N  = 8,
   parameter int unsigned K  = 3,
   parameter int unsigned W  = 12,
   parameter int unsigned RW = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  flush,
   input  logic                  in_vld,
   input  logic                  in_last,
   input  logic [RW-1:0]         in_row,
   input  logic [W-1:0]          in_re,
   input  logic [W-1:0]          in_im,
   output logic [K-1:0]          tap_vld,
   output logic [K-1:0][RW-1:0]  tap_row,
   output logic [K-1:0][W-1:0]   tap_re,
   output logic [K-1:0][W-1:0]   tap_im,
   output logic                  last_out,
   output logic [K-1:0][W-1:0]   cj_re,
   output logic [K-1:0][W:0]     cj_im
);

   if (K < 1 || K > N) begin : g_bad_k
      $error("pac_skew_line: K must lie in 1..N");
   end

   logic [K-1:0] tap_last;
   assign last_out = tap_last[K-1];

   // stage s holds a sample s+1 edges old; column unit s reads stage s
   for (genvar s = 0; s < K; s++) begin : g_stage
      if (s == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tap_vld[0]  <= 1'b0;
               tap_last[0] <= 1'b0;
               tap_row[0]  <= '0;
               tap_re[0]   <= '0;
               tap_im[0]   <= '0;
            end else begin
               tap_vld[0]  <= in_vld;
               tap_last[0] <= in_vld & in_last;
               tap_row[0]  <= in_row;
               tap_re[0]   <= in_re;
               tap_im[0]   <= in_im;
            end
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tap_vld[s]  <= 1'b0;
               tap_last[s] <= 1'b0;
               tap_row[s]  <= '0;
               tap_re[s]   <= '0;
               tap_im[s]   <= '0;
            end else begin
               tap_vld[s]  <= tap_vld[s-1] & ~flush;
               tap_last[s] <= tap_last[s-1] & ~flush;
               tap_row[s]  <= tap_row[s-1];
               tap_re[s]   <= tap_re[s-1];
               tap_im[s]   <= tap_im[s-1];
            end
         end
      end
   end

   // conjugate bank: one extra bit so that -(-2^(W-1)) is representable
   for (genvar c = 0; c < K; c++) begin : g_conj
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cj_re[c] <= '0;
            cj_im[c] <= '0;
         end else if (in_vld && in_row == RW'(c)) begin
            cj_re[c] <= in_re;
            cj_im[c] <= -{in_im[W-1], in_im};
         end
      end
   end

endmodule

// File: rtl/pac_cmac.sv
module pac_cmac #(
   parameter int unsigned N     = 8,
   parameter int unsigned W     = 12,
   parameter int unsigned ACC_W = 31,
   parameter int unsigned RW    = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr,
   input  logic                      vld,
   input  logic [RW-1:0]             row,
   input  logic signed [W-1:0]       xr,
   input  logic signed [W-1:0]       xi,
   input  logic signed [W-1:0]       cr,
   input  logic signed [W:0]         ci,
   output logic [N-1:0][ACC_W-1:0]   acc_re,
   output logic [N-1:0][ACC_W-1:0]   acc_im
);

   localparam int unsigned PW = 2 * W + 1;

   if (ACC_W < PW) begin : g_bad_acc
      $error("pac_cmac: accumulator narrower than one product");
   end

   logic signed [PW-1:0]    p_re, p_im;
   logic signed [ACC_W:0]   nx_re, nx_im;

   always_comb begin
      p_re  = PW'(xr) * PW'(cr) - PW'(xi) * PW'(ci);
      p_im  = PW'(xr) * PW'(ci) + PW'(xi) * PW'(cr);
      nx_re = $signed({acc_re[row][ACC_W-1], acc_re[row]}) + (ACC_W+1)'(p_re);
      nx_im = $signed({acc_im[row][ACC_W-1], acc_im[row]}) + (ACC_W+1)'(p_im);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_re <= '0;
         acc_im <= '0;
      end else if (clr) begin
         acc_re <= '0;
         acc_im <= '0;
      end else if (vld) begin
         acc_re[row] <= nx_re[ACC_W-1:0];
         acc_im[row] <= nx_im[ACC_W-1:0];
      end
   end

   // R2: a clear leaves every row of this column at zero
   a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc_re == '0 && acc_im == '0));

   // R10: the widened sum never leaves the accumulator range
   a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && !clr) |-> (nx_re[ACC_W] == nx_re[ACC_W-1] &&
                         nx_im[ACC_W] == nx_im[ACC_W-1]));

endmodule

// File: rtl/pac_round.sv
module pac_round #(
   parameter int unsigned ACC_W = 31,
   parameter int unsigned LG    = 6,
   parameter int unsigned OUT_W = 25
) (
   input  logic [ACC_W-1:0] acc,
   output logic [OUT_W-1:0] avg
);

   if (OUT_W + LG != ACC_W) begin : g_bad_w
      $error("pac_round: OUT_W must equal ACC_W - LG");
   end

   if (LG == 0) begin : g_pass
      assign avg = acc[OUT_W-1:0];
   end else begin : g_shift
      localparam logic [ACC_W:0] HALF = (ACC_W+1)'(1) << (LG - 1);
      logic [ACC_W:0]        biased;
      logic signed [ACC_W:0] shifted;
      assign biased  = {acc[ACC_W-1], acc} + HALF;
      assign shifted = $signed(biased) >>> LG;
      assign avg     = shifted[OUT_W-1:0];
   end

endmodule

// File: rtl/partial_autocorr_acc.sv
module partial_autocorr_acc
   import pac_pkg::*;
#(
   parameter int unsigned N_ELEM     = DEF_N,
   parameter int unsigned K_COLS     = DEF_K,
   parameter int unsigned SAMP_W     = DEF_W,
   parameter int unsigned LOG2_SNAPS = DEF_LG
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic                                       start,
   input  logic [SAMP_W-1:0]                          smp_re,
   input  logic [SAMP_W-1:0]                          smp_im,
   output logic                                       done,
   output logic [N_ELEM*K_COLS*(2*SAMP_W+1)-1:0]      avg_re,
   output logic [N_ELEM*K_COLS*(2*SAMP_W+1)-1:0]      avg_im
);

   localparam int unsigned ACC_W = acc_width(SAMP_W, LOG2_SNAPS);
   localparam int unsigned OUT_W = 2 * SAMP_W + 1;
   localparam int unsigned RW    = idx_width(N_ELEM);
   localparam int unsigned TOTAL = N_ELEM << LOG2_SNAPS;
   localparam int unsigned CW    = $clog2(TOTAL + 1);

   if (K_COLS < 1 || K_COLS > N_ELEM) begin : g_bad_k
      $error("partial_autocorr_acc: K_COLS must lie in 1..N_ELEM");
   end
   if (SAMP_W < 2) begin : g_bad_w
      $error("partial_autocorr_acc: SAMP_W too small");
   end

   // ---------------- snapshot sequencing ----------------
   logic           running, have_res;
   logic [CW-1:0]  cnt;
   logic [RW-1:0]  row;
   logic           cap, cur_last;
   logic [RW-1:0]  cur_row;

   function automatic logic [RW-1:0] step_row(logic [RW-1:0] r);
      return (r == RW'(N_ELEM - 1)) ? '0 : r + RW'(1);
   endfunction

   assign cap      = start | running;
   assign cur_row  = start ? '0 : row;
   assign cur_last = start ? (TOTAL == 1) : (cnt == CW'(TOTAL - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         cnt     <= '0;
         row     <= '0;
      end else if (start) begin
         running <= (TOTAL > 1);
         cnt     <= CW'(1);
         row     <= step_row('0);
      end else if (running) begin
         cnt <= cnt + CW'(1);
         row <= step_row(row);
         if (cnt == CW'(TOTAL - 1)) running <= 1'b0;
      end
   end

   // ---------------- delay line and conjugate bank ----------------
   logic [K_COLS-1:0]              tap_vld;
   logic [K_COLS-1:0][RW-1:0]      tap_row;
   logic [K_COLS-1:0][SAMP_W-1:0]  tap_re, tap_im, cj_re;
   logic [K_COLS-1:0][SAMP_W:0]    cj_im;
   logic                           last_out;

   pac_skew_line #(.N(N_ELEM), .K(K_COLS), .W(SAMP_W), .RW(RW)) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (start),
      .in_vld   (cap),
      .in_last  (cur_last),
      .in_row   (cur_row),
      .in_re    (smp_re),
      .in_im    (smp_im),
      .tap_vld  (tap_vld),
      .tap_row  (tap_row),
      .tap_re   (tap_re),
      .tap_im   (tap_im),
      .last_out (last_out),
      .cj_re    (cj_re),
      .cj_im    (cj_im)
   );

   // ---------------- column units ----------------
   logic [K_COLS-1:0][N_ELEM-1:0][ACC_W-1:0] acc_re, acc_im;

   for (genvar j = 0; j < K_COLS; j++) begin : g_col
      pac_cmac #(.N(N_ELEM), .W(SAMP_W), .ACC_W(ACC_W), .RW(RW)) u_mac (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (start),
         .vld    (tap_vld[j]),
         .row    (tap_row[j]),
         .xr     (tap_re[j]),
         .xi     (tap_im[j]),
         .cr     (cj_re[j]),
         .ci     (cj_im[j]),
         .acc_re (acc_re[j]),
         .acc_im (acc_im[j])
      );

      for (genvar i = 0; i < N_ELEM; i++) begin : g_row
         pac_round #(.ACC_W(ACC_W), .LG(LOG2_SNAPS), .OUT_W(OUT_W)) u_rre (
            .acc (acc_re[j][i]),
            .avg (avg_re[(i*K_COLS+j)*OUT_W +: OUT_W])
         );
         pac_round #(.ACC_W(ACC_W), .LG(LOG2_SNAPS), .OUT_W(OUT_W)) u_rim (
            .acc (acc_im[j][i]),
            .avg (avg_im[(i*K_COLS+j)*OUT_W +: OUT_W])
         );
      end
   end

   // ---------------- completion ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done     <= 1'b0;
         have_res <= 1'b0;
      end else begin
         done     <= ~start & last_out;
         have_res <= start ? 1'b0 : (have_res | done);
      end
   end

   // R7: completion is a single-cycle pulse
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: completion never overlaps the capture window
   a_r7_done_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !running);

   // R8: a finished result holds until a new start
   a_r8_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
      (have_res && !start) |=> ($stable(avg_re) && $stable(avg_im)));

   // R3: a start always opens a capture window
   a_r3_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (running || TOTAL == 1));

endmodule

// File: tb/tb_partial_autocorr_acc.sv
module tb_partial_autocorr_acc;

   localparam int N   = 8;
   localparam int K   = 3;
   localparam int W   = 12;
   localparam int LG  = 6;
   localparam int TOT = N << LG;
   localparam int OW  = 2 * W + 1;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                start = 1'b0;
   logic [W-1:0]        smp_re = '0, smp_im = '0;
   logic                done;
   logic [N*K*OW-1:0]   avg_re, avg_im;

   partial_autocorr_acc #(.N_ELEM(N), .K_COLS(K), .SAMP_W(W), .LOG2_SNAPS(LG)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .smp_re(smp_re), .smp_im(smp_im),
      .done(done), .avg_re(avg_re), .avg_im(avg_im)
   );

   always #2.5 clk = ~clk;

   int nchk = 0, nfail = 0;
   int xr[TOT], xi[TOT];

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint rnd_avg(input longint s);
      return (s + (longint'(1) << (LG - 1))) >>> LG;
   endfunction

   function automatic longint ref_re(input int i, input int j);
      longint s = 0;
      for (int n = 0; n < (1 << LG); n++)
         s += longint'(xr[n*N+i]) * xr[n*N+j] + longint'(xi[n*N+i]) * xi[n*N+j];
      return rnd_avg(s);
   endfunction

   function automatic longint ref_im(input int i, input int j);
      longint s = 0;
      for (int n = 0; n < (1 << LG); n++)
         s += longint'(xi[n*N+i]) * xr[n*N+j] - longint'(xr[n*N+i]) * xi[n*N+j];
      return rnd_avg(s);
   endfunction

   function automatic longint got_re(input int i, input int j);
      return longint'($signed(avg_re[(i*K+j)*OW +: OW]));
   endfunction

   function automatic longint got_im(input int i, input int j);
      return longint'($signed(avg_im[(i*K+j)*OW +: OW]));
   endfunction

   task automatic chk_all_zero(input string req);
      bit z = 1'b1;
      for (int i = 0; i < N; i++)
         for (int j = 0; j < K; j++)
            if (got_re(i, j) != 0 || got_im(i, j) != 0) z = 1'b0;
      chk(z, req, z, 1);
   endtask

   task automatic chk_matrix(input string req);
      for (int i = 0; i < N; i++)
         for (int j = 0; j < K; j++) begin
            chk(got_re(i, j) == ref_re(i, j), req, got_re(i, j), ref_re(i, j));
            chk(got_im(i, j) == ref_im(i, j), req, got_im(i, j), ref_im(i, j));
         end
   endtask

   function automatic int rnd_s();
      return int'($urandom_range(4095)) - 2048;
   endfunction

   // 0 random, 1 all most-negative, 2 extreme magnitudes, 3 tie pattern, 4 ramp
   task automatic fill(input int mode);
      for (int m = 0; m < TOT; m++) begin
         case (mode)
            0: begin xr[m] = rnd_s(); xi[m] = rnd_s(); end
            1: begin xr[m] = -2048; xi[m] = -2048; end
            2: begin xr[m] = $urandom_range(1) ? 2047 : -2048;
                     xi[m] = $urandom_range(1) ? 2047 : -2048; end
            3: begin xr[m] = 0; xi[m] = 0; end
            default: begin xr[m] = (m % N + 1) * 97 - (m / N);
                           xi[m] = (m / N) - (m % N) * 53; end
         endcase
      end
      if (mode == 3) begin
         xr[0] = 4; xr[1] = 8; xr[2] = -8;
      end
   endtask

   task automatic run_full(input string tag);
      bit early = 1'b0;
      for (int m = 0; m < TOT; m++) begin
         @(negedge clk);
         if (m == 1) chk_all_zero({"R2 clear after start ", tag});
         if (done) early = 1'b1;
         start  = (m == 0);
         smp_re = W'(xr[m]);
         smp_im = W'(xi[m]);
      end
      chk(!early, {"R9/R7 no early done ", tag}, early, 0);
      // negedge e+1 observes the state after edge e
      for (int e = TOT - 1; e <= TOT + K; e++) begin
         @(negedge clk);
         start  = 1'b0;
         smp_re = W'(rnd_s());
         smp_im = W'(rnd_s());
         chk(done == (e == TOT + K - 1), {"R7 done timing ", tag}, done, e == TOT + K - 1);
      end
      chk_matrix({"R4 matrix ", tag});
   endtask

   bit finished = 1'b0;

   initial begin
      #(200000 * 5);
      if (!finished) begin
         nfail++;
         $display("FAIL R7 watchdog expired actual=0 expected=1");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1357_9bdf));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(done == 1'b0, "R1 done after reset", done, 0);
      chk_all_zero("R1 outputs after reset");

      // R3, R4: random snapshots
      fill(0);
      run_full("R3 random");

      // R8: garbage after the window is ignored, result holds
      repeat (20) begin
         @(negedge clk);
         smp_re = W'(rnd_s());
         smp_im = W'(rnd_s());
         if (done) chk(1'b0, "R8 spurious done", 1, 0);
      end
      chk_matrix("R8 held result");

      // R6: ramp tells rows and columns apart
      fill(4);
      run_full("R6 ramp");

      // R10: full scale, most negative on both parts
      fill(1);
      run_full("R10 all -2048");
      chk(got_re(0, 0) == (longint'(1) << 23), "R10 peak real", got_re(0, 0), longint'(1) << 23);
      fill(2);
      run_full("R10 extremes");

      // R5: exact halves round upward
      fill(3);
      run_full("R5 ties");
      chk(got_re(1, 0) == 1, "R5 tie +32", got_re(1, 0), 1);
      chk(got_re(2, 0) == 0, "R5 tie -32", got_re(2, 0), 0);
      chk(got_re(0, 0) == 0, "R5 quarter 16", got_re(0, 0), 0);

      // R9: abort mid-run, then restart with fresh data
      for (int m = 0; m < 200; m++) begin
         @(negedge clk);
         start  = (m == 0);
         smp_re = W'(rnd_s());
         smp_im = W'(rnd_s());
         if (done) chk(1'b0, "R9 done during aborted run", 1, 0);
      end
      fill(0);
      run_full("R9 restart");

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule